// File: doc/BRIEF.md
# Virtual Interrupt Arbiter and Signaller

This block chooses which pending virtual interrupt a virtual CPU interface should present next. The candidates are a set of list-register entries and one directly injected virtual LPI. Each list-register entry carries a pending flag, a group bit and a priority value. The LPI candidate brings its own priority and group. The arbiter is purely combinational. It reports the winning slot number and a valid flag. Slots 0 to NUM_LR-1 are list registers, and slot 16 is reserved for the LPI candidate.

The winner is then tested against the interface enable, the virtual priority mask and the priority of the highest active interrupt. Only the group-priority bits take part in that last comparison, as chosen by a per-group binary-point input. If the winner passes every test, a registered output line is raised on the next clock edge: the FIQ line for group 0, the IRQ line for group 1. All decisions are recomputed every cycle. A change of security state is therefore reflected on the lines at the next edge.

Top module: `vint_arbiter`

## Requirements
- R1: Among list-register entries that are pending, whose group enable is set (`ven_g0` for group bit 0, `ven_g1` for group bit 1) and whose priority value is below 0xFF, the lowest priority value wins. Ties go to the lowest entry number, and `win_idx` reports that entry number with `win_valid` high.
- R2: When no candidate qualifies, `win_valid` is low and `win_idx` is 5'h1F. Both lines are then low after the next edge.
- R3: The LPI candidate wins, and `win_idx` is 16, only if all of the following hold: `nonsecure` is high, its group enable is set, and its priority is strictly lower than the best qualifying list-register priority (0xFF when there is none). A priority of 0xFF therefore never wins, and an equal priority loses to the list register.
- R4: With `vif_en` low, both lines are low after the next edge, whatever the candidates are.
- R5: A winner is signalled only if its priority is strictly below `vpmr`.
- R6: When `run_prio` is 0xFF, a winner that passes R4 and R5 is always signalled.
- R7: Otherwise, a winner is signalled only if (winner priority AND mask) < (`run_prio` AND mask). The mask is all ones shifted left by (binary point + 1), and it uses `bpr_g0` or `bpr_g1` according to the winner's group.
- R8: A signalled group-0 winner raises `vfiq`, and a signalled group-1 winner raises `virq`. The lines are registered, so they show the decision made from the inputs present at the previous rising edge. Both are low in reset.
- R9: When `nonsecure` falls while the LPI candidate is the signalled winner, the arbitration drops it at once, and its line falls at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lr_pend | input | NUM_LR | Pending flag per list-register entry |
| lr_grp | input | NUM_LR | Group bit per entry (1 = group 1) |
| lr_prio | input | NUM_LR*PRIO_W | Priority per entry, entry i at bits [i*PRIO_W +: PRIO_W] |
| lpi_prio | input | PRIO_W | LPI candidate priority, all ones = none |
| lpi_grp | input | 1 | LPI candidate group |
| nonsecure | input | 1 | Interface is in non-secure state |
| ven_g0 | input | 1 | Virtual group-0 enable |
| ven_g1 | input | 1 | Virtual group-1 enable |
| vif_en | input | 1 | Virtual interface enable |
| vpmr | input | PRIO_W | Virtual priority mask |
| bpr_g0 | input | BP_W | Group-0 binary point |
| bpr_g1 | input | BP_W | Group-1 binary point |
| run_prio | input | PRIO_W | Highest active priority, all ones = idle |
| win_idx | output | 5 | Winning slot, 16 = LPI, 31 = none |
| win_valid | output | 1 | A winner exists |
| virq | output | 1 | Registered virtual IRQ line |
| vfiq | output | 1 | Registered virtual FIQ line |

## Verification
The bench uses the default parameters: sixteen list-register entries and 8-bit priorities. With these values, entry 15 and the reserved LPI slot 16 sit next to each other in the index encoding, and binary points 0 to 7 cover every mask from 0xFE down to zero. This puts the full-width tie scan, the all-masked case (where nothing can preempt a running interrupt) and the subpriority-only difference within reach.

// File: rtl/vint_pkg.sv
package vint_pkg;
   localparam int IDX_W = 5;
   localparam logic [IDX_W-1:0] LPI_SLOT = 5'd16;
   localparam logic [IDX_W-1:0] IDX_NONE = 5'h1F;
   typedef enum logic {VGRP0 = 1'b0, VGRP1 = 1'b1} vgrp_e;
endpackage

// File: rtl/vint_lr_pick.sv
module vint_lr_pick
   import vint_pkg::*;
#(
   parameter int NUM_LR = 16,
   parameter int PRIO_W = 8
) (
   input  logic [NUM_LR-1:0]        lr_pend,
   input  logic [NUM_LR-1:0]        lr_grp,
   input  logic [NUM_LR*PRIO_W-1:0] lr_prio,
   input  logic                     ven_g0,
   input  logic                     ven_g1,
   output logic                     found,
   output logic [IDX_W-1:0]         best_idx,
   output logic [PRIO_W-1:0]        best_prio,
   output vgrp_e                    best_grp
);
   localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};

   logic [NUM_LR-1:0] eligible;
   logic [PRIO_W-1:0] entry_prio [NUM_LR];

   // per-entry qualification
   for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
      assign entry_prio[i] = lr_prio[i*PRIO_W +: PRIO_W];
      assign eligible[i]   = lr_pend[i] && (lr_grp[i] ? ven_g1 : ven_g0);
   end

   // strict-less scan keeps the lowest index on ties
   always_comb begin
      found     = 1'b0;
      best_idx  = IDX_NONE;
      best_prio = PRIO_IDLE;
      best_grp  = VGRP0;
      for (int i = 0; i < NUM_LR; i++) begin
         if (eligible[i] && (entry_prio[i] < best_prio)) begin
            found     = 1'b1;
            best_idx  = IDX_W'(i);
            best_prio = entry_prio[i];
            best_grp  = vgrp_e'(lr_grp[i]);
         end
      end
   end
endmodule

// File: rtl/vint_preempt.sv
module vint_preempt
   import vint_pkg::*;
#(
   parameter int PRIO_W = 8,
   parameter int BP_W   = 3
) (
   input  logic              cand_valid,
   input  logic [PRIO_W-1:0] cand_prio,
   input  vgrp_e             cand_grp,
   input  logic              vif_en,
   input  logic [PRIO_W-1:0] vpmr,
   input  logic [BP_W-1:0]   bpr_g0,
   input  logic [BP_W-1:0]   bpr_g1,
   input  logic [PRIO_W-1:0] run_prio,
   output logic              can_signal
);
   localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};

   logic [BP_W-1:0]   bpr_sel;
   logic [BP_W:0]     shift_amt;
   logic [PRIO_W-1:0] gmask;
   logic              passes_mask;
   logic              beats_running;

   assign bpr_sel       = (cand_grp == VGRP1) ? bpr_g1 : bpr_g0;
   assign shift_amt     = {1'b0, bpr_sel} + 1'b1;
   assign gmask         = PRIO_IDLE << shift_amt;
   assign passes_mask   = cand_prio < vpmr;
   assign beats_running = (run_prio == PRIO_IDLE) ||
                          ((cand_prio & gmask) < (run_prio & gmask));
   assign can_signal    = cand_valid && vif_en && passes_mask && beats_running;
endmodule

// File: rtl/vint_arbiter.sv
module vint_arbiter
   import vint_pkg::*;
#(
   parameter int NUM_LR = 16,
   parameter int PRIO_W = 8,
   localparam int BP_W  = $clog2(PRIO_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_LR-1:0]        lr_pend,
   input  logic [NUM_LR-1:0]        lr_grp,
   input  logic [NUM_LR*PRIO_W-1:0] lr_prio,
   input  logic [PRIO_W-1:0]        lpi_prio,
   input  logic                     lpi_grp,
   input  logic                     nonsecure,
   input  logic                     ven_g0,
   input  logic                     ven_g1,
   input  logic                     vif_en,
   input  logic [PRIO_W-1:0]        vpmr,
   input  logic [BP_W-1:0]          bpr_g0,
   input  logic [BP_W-1:0]          bpr_g1,
   input  logic [PRIO_W-1:0]        run_prio,
   output logic [IDX_W-1:0]         win_idx,
   output logic                     win_valid,
   output logic                     virq,
   output logic                     vfiq
);
   localparam int LR_IW = (NUM_LR > 1) ? $clog2(NUM_LR) : 1;
   localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};

   if (NUM_LR < 1 || NUM_LR > 16) begin : g_bad_lr
      $error("NUM_LR must lie in 1..16");
   end
   if (PRIO_W < 4 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must lie in 4..8");
   end

   logic              lr_found;
   logic [IDX_W-1:0]  lr_idx;
   logic [PRIO_W-1:0] lr_best;
   vgrp_e             lr_bgrp;
   logic              lpi_wins;
   logic [PRIO_W-1:0] win_prio;
   vgrp_e             win_grp;
   logic              can_signal;

   vint_lr_pick #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) u_pick (
      .lr_pend  (lr_pend),
      .lr_grp   (lr_grp),
      .lr_prio  (lr_prio),
      .ven_g0   (ven_g0),
      .ven_g1   (ven_g1),
      .found    (lr_found),
      .best_idx (lr_idx),
      .best_prio(lr_best),
      .best_grp (lr_bgrp)
   );

   // LPI candidate competes only in non-secure state with its group enabled
   assign lpi_wins  = nonsecure && (lpi_grp ? ven_g1 : ven_g0) && (lpi_prio < lr_best);
   assign win_idx   = lpi_wins ? LPI_SLOT : lr_idx;
   assign win_valid = lpi_wins || lr_found;
   assign win_prio  = lpi_wins ? lpi_prio : lr_best;
   assign win_grp   = lpi_wins ? vgrp_e'(lpi_grp) : lr_bgrp;

   vint_preempt #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_pre (
      .cand_valid(win_valid),
      .cand_prio (win_prio),
      .cand_grp  (win_grp),
      .vif_en    (vif_en),
      .vpmr      (vpmr),
      .bpr_g0    (bpr_g0),
      .bpr_g1    (bpr_g1),
      .run_prio  (run_prio),
      .can_signal(can_signal)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         virq <= 1'b0;
         vfiq <= 1'b0;
      end else begin
         virq <= can_signal && (win_grp == VGRP1);
         vfiq <= can_signal && (win_grp == VGRP0);
      end
   end

   assert_winner_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_idx < NUM_LR) |-> lr_pend[win_idx[LR_IW-1:0]]);
   assert_none_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid |-> (win_idx == IDX_NONE));
   assert_none_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid |=> (!virq && !vfiq));
   assert_lpi_nonsecure_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_idx == LPI_SLOT) |-> (nonsecure && lpi_prio != PRIO_IDLE));
   assert_if_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !vif_en |=> (!virq && !vfiq));
   assert_pmr_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_prio >= vpmr) |=> (!virq && !vfiq));
   assert_idle_signal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && vif_en && win_prio < vpmr && run_prio == PRIO_IDLE) |=> (virq || vfiq));
   assert_grp1_no_fiq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_grp == VGRP1) |=> !vfiq);
endmodule

// File: tb/vint_arbiter_bench.sv
`timescale 1ns/1ps
module vint_arbiter_bench;
   localparam int NLR = 16;
   localparam int PW  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NLR-1:0]    pend, grp;
   logic [PW-1:0]     pr [NLR];
   logic [NLR*PW-1:0] prio_flat;
   logic [PW-1:0]     lp, vpmr, runp;
   logic              lg, ns, e0, e1, ven;
   logic [2:0]        b0, b1;
   logic [4:0]        win_idx;
   logic              win_valid, virq, vfiq;

   for (genvar i = 0; i < NLR; i++) begin : g_flat
      assign prio_flat[i*PW +: PW] = pr[i];
   end

   vint_arbiter u_vint_arbiter (
      .clk(clk), .rst_n(rst_n), .lr_pend(pend), .lr_grp(grp), .lr_prio(prio_flat),
      .lpi_prio(lp), .lpi_grp(lg), .nonsecure(ns), .ven_g0(e0), .ven_g1(e1),
      .vif_en(ven), .vpmr(vpmr), .bpr_g0(b0), .bpr_g1(b1), .run_prio(runp),
      .win_idx(win_idx), .win_valid(win_valid), .virq(virq), .vfiq(vfiq));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model(output logic [4:0] idx, output logic v, output logic irq, output logic fiq);
      logic [7:0] best = 8'hFF;
      logic       bg = 1'b0;
      logic [7:0] m;
      logic       can;
      idx = 5'h1F;
      for (int i = 0; i < NLR; i++)
         if (pend[i] && (grp[i] ? e1 : e0) && pr[i] < best) begin
            best = pr[i]; idx = 5'(i); bg = grp[i];
         end
      if (ns && (lg ? e1 : e0) && lp < best) begin
         best = lp; idx = 5'd16; bg = lg;
      end
      v = (idx != 5'h1F);
      m = 8'((32'hFF << (int'(bg ? b1 : b0) + 1)) & 32'hFF);
      can = v && ven && (best < vpmr) && (runp == 8'hFF || ((best & m) < (runp & m)));
      irq = can && bg;
      fiq = can && !bg;
   endtask

   // called just after a falling edge with inputs already set
   task automatic run_vec(input string tag);
      logic [4:0] ei;
      logic ev, eirq, efiq;
      #1;
      model(ei, ev, eirq, efiq);
      chk({tag, " idx"}, 32'(win_idx), 32'(ei));
      chk({tag, " valid"}, 32'(win_valid), 32'(ev));
      @(posedge clk); #1;
      chk({tag, " virq"}, 32'(virq), 32'(eirq));
      chk({tag, " vfiq"}, 32'(vfiq), 32'(efiq));
      @(negedge clk);
   endtask

   task automatic quiet();
      pend = '0; grp = '0;
      for (int i = 0; i < NLR; i++) pr[i] = 8'hFF;
      lp = 8'hFF; lg = 1'b0; ns = 1'b1; e0 = 1'b1; e1 = 1'b1; ven = 1'b1;
      vpmr = 8'hFF; runp = 8'hFF; b0 = 3'd0; b1 = 3'd0;
   endtask

   function automatic logic [7:0] rprio();
      case ($urandom % 6)
         0: return 8'h10;
         1: return 8'h20;
         2: return 8'hFF;
         3: return 8'h28;
         default: return 8'($urandom);
      endcase
   endfunction

   logic done = 1'b0;
   initial begin
      #(5ns * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1729));
      quiet();
      pend = 16'h0003; pr[0] = 8'h10; pr[1] = 8'h10;
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset virq", 32'(virq), 32'd0);
      chk("R8 reset vfiq", 32'(vfiq), 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      quiet(); run_vec("R2 nothing pending");
      quiet(); pend[5] = 1'b1; pr[5] = 8'hFF; run_vec("R1 R2 lr prio FF ignored");
      quiet(); pend = 16'h8420; pr[5] = 8'h30; pr[10] = 8'h30; pr[15] = 8'h30; grp = 16'hFFFF;
      run_vec("R1 tie lowest index");
      quiet(); pend = 16'h8001; pr[0] = 8'h40; pr[15] = 8'h08; grp[15] = 1'b1; run_vec("R1 R8 entry 15 wins irq");
      quiet(); pend[3] = 1'b1; grp[3] = 1'b1; pr[3] = 8'h10; e1 = 1'b0; run_vec("R1 group disabled");
      quiet(); pend[2] = 1'b1; pr[2] = 8'h20; lp = 8'h20; lg = 1'b1; run_vec("R3 equal lpi loses");
      quiet(); pend[2] = 1'b1; pr[2] = 8'h20; lp = 8'h1F; lg = 1'b1; run_vec("R3 lower lpi wins");
      quiet(); pend[2] = 1'b1; pr[2] = 8'h20; lp = 8'h1F; ns = 1'b0; run_vec("R3 secure blocks lpi");
      quiet(); lp = 8'hFF; run_vec("R3 lpi FF none");
      quiet(); lp = 8'h10; lg = 1'b0; e0 = 1'b0; run_vec("R3 lpi group off");
      quiet(); pend[1] = 1'b1; pr[1] = 8'h10; ven = 1'b0; run_vec("R4 interface off");
      quiet(); pend[1] = 1'b1; pr[1] = 8'h40; vpmr = 8'h40; run_vec("R5 equal mask blocks");
      quiet(); pend[1] = 1'b1; pr[1] = 8'h3F; vpmr = 8'h40; run_vec("R5 below mask passes");
      quiet(); pend[1] = 1'b1; pr[1] = 8'hFE; run_vec("R6 idle runs any");
      quiet(); pend[4] = 1'b1; grp[4] = 1'b1; pr[4] = 8'h21; runp = 8'h28; b1 = 3'd3; b0 = 3'd0;
      run_vec("R7 subpriority ignored");
      quiet(); pend[4] = 1'b1; grp[4] = 1'b1; pr[4] = 8'h18; runp = 8'h28; b1 = 3'd3; run_vec("R7 group prio beats");
      quiet(); pend[4] = 1'b1; pr[4] = 8'h21; runp = 8'h28; b0 = 3'd0; b1 = 3'd3; run_vec("R7 R8 group0 mask fiq");
      quiet(); pend[4] = 1'b1; pr[4] = 8'h00; runp = 8'h80; b0 = 3'd7; run_vec("R7 all masked");
      quiet(); lp = 8'h10; lg = 1'b1; run_vec("R9 lpi signalled");
      ns = 1'b0; run_vec("R9 secure drops lpi");

      for (int k = 0; k < 1500; k++) begin
         pend = 16'($urandom); grp = 16'($urandom);
         for (int i = 0; i < NLR; i++) pr[i] = rprio();
         if ($urandom % 3 == 0) pend = pend & 16'h000F;
         lp = rprio(); lg = 1'($urandom); ns = ($urandom % 4) != 0;
         e0 = ($urandom % 5) != 0; e1 = ($urandom % 5) != 0; ven = ($urandom % 8) != 0;
         vpmr = ($urandom % 2) ? 8'hFF : rprio();
         runp = ($urandom % 2) ? 8'hFF : rprio();
         b0 = 3'($urandom); b1 = 3'($urandom);
         run_vec("R1 R3 R5 R7 R8 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule